// File: doc/BRIEF.md
# Serial Clock-Enable Register Target

This block is a two-wire serial bus target that holds the enable bits for a bank of board clock outputs. It answers only two transfer kinds: a block write, which loads the bank starting at register 0, and a block read, which returns a length byte and then the bank starting at register 0. Serial clock and data come in as plain inputs. The target pulls the data line low through an open-drain enable output, and the whole bank is presented as a flat parallel word to the clock-gating logic.

Both bus pins are oversampled with the block's system clock. A synchronizer and edge detector turn the pins into rise, fall, START and STOP events. A byte engine frames 9-clock byte slots, checks the address, command and length, and drives ACK/NACK and read data. A register bank holds five bytes that reset to all ones. When the power-down input is high, the target drops off the bus and keeps its register contents.

In the parallel word, register 0 enables the eight lowest bus clocks. Register 1 enables four more bus clocks in bits 7..4, the two 48 MHz clocks in bits 3..2 and the two reference copies in bits 1..0. Register 2 bits 7..2 enable the six 66 MHz clocks. The remaining bits are reserved but can still be stored.

Top module: `smb_clk_en_regs`

## Requirements
- R1: A first byte whose upper seven bits are 1101001 is acknowledged; any other address gets no ACK, and the target neither drives SDA nor changes a register until the next START.
- R2: In a write, the byte after the address must be 0x00 and is ACKed; any other value is NACKed, and the rest of the transfer is ignored.
- R3: A length byte of 1 to 5 is ACKed, and that many data bytes are ACKed and stored in registers 0, 1, 2... in that order, each byte received MSB first; register k appears on en_regs_o[8k+7:8k].
- R4: A length byte of 0 or above 32 is NACKed, and no register changes.
- R5: A length byte of 6 to 31 is ACKed, and that many data bytes are ACKed, but no register changes.
- R6: A length byte of 32 is ACKed, all 32 data bytes are ACKed, the first five are stored in registers 0..4 and the rest are dropped.
- R7: A data byte sent after the announced length is NACKed and not stored.
- R8: After an address byte with R/W = 1, the target sends the length value 5 and then registers 0..4 in order, MSB first.
- R9: If the host ACKs the byte carrying register 4, every further byte the target sends is 0xFF (SDA released).
- R10: A host NACK after any byte sent by the target makes it release SDA and keep it released until the next START.
- R11: After reset every register bit is 1 and SDA is released.
- R12: While pwr_dn_i is high, SDA is released from the cycle after it rises, bus activity is ignored and register contents are held; after it falls, normal transfers work again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_dn_i | input | 1 | Power-down: releases the bus and freezes the registers |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level (wired line) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| en_regs_o | output | NREG*8 (40) | Register bank, register k in bits 8k+7..8k |

## Verification
The case where two functions coincide is power-down arriving while the target holds SDA low for an address ACK. The bench raises pwr_dn_i in the middle of the high phase of that ACK clock. It checks that sda_oe_o is low two system clocks later, that the data bytes the host goes on sending are neither ACKed nor stored, and that a normal write succeeds once power-down is removed. Separate transfers cover each length class and early host NACKs, against a register model kept in the bench.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_WDATA,
    PH_TXCNT,
    PH_TXDATA,
    PH_IGNORE
  } phase_e;
endpackage

// File: rtl/smb_edge.sv
module smb_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_o      = scl_q[1];
  assign sda_o      = sda_q[1];
  assign scl_rise_o = scl_q[1] & ~scl_q[2];
  assign scl_fall_o = ~scl_q[1] & scl_q[2];
  // data edge while clock stays high
  assign start_o    = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  assign stop_o     = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int NREG = 5,
  parameter int AW   = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [AW-1:0]                 waddr_i,
  input  logic [smb_pkg::BYTE_W-1:0]    wdata_i,
  input  logic [AW-1:0]                 raddr_i,
  output logic [smb_pkg::BYTE_W-1:0]    rdata_o,
  output logic [NREG*smb_pkg::BYTE_W-1:0] regs_o
);
  localparam int BW = smb_pkg::BYTE_W;

  logic [BW-1:0] mem_q [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[k] <= '1;
      else if (we_i && waddr_i == AW'(k))       mem_q[k] <= wdata_i;
    end
    assign regs_o[k*BW +: BW] = mem_q[k];
  end

  always_comb begin
    rdata_o = '1;
    for (int k = 0; k < NREG; k++)
      if (raddr_i == AW'(k)) rdata_o = mem_q[k];
  end

  // R3
  wr_addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (waddr_i < AW'(NREG)));
endmodule

// File: rtl/smb_engine.sv
module smb_engine #(
  parameter logic [6:0] DEV_ADDR = 7'b1101001,
  parameter int         NREG     = 5,
  parameter int         MAX_CNT  = 32,
  parameter int         AW       = 3,
  parameter int         IDX_W    = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       pwr_dn_i,
  input  logic                       scl_lvl_i,
  input  logic                       sda_lvl_i,
  input  logic                       scl_rise_i,
  input  logic                       scl_fall_i,
  input  logic                       start_i,
  input  logic                       stop_i,
  input  logic [smb_pkg::BYTE_W-1:0] rdata_i,
  output logic [AW-1:0]              raddr_o,
  output logic                       we_o,
  output logic [AW-1:0]              waddr_o,
  output logic [smb_pkg::BYTE_W-1:0] wdata_o,
  output logic                       sda_oe_o
);
  import smb_pkg::*;

  localparam logic [BYTE_W-1:0] LEN_B   = BYTE_W'(NREG);
  localparam logic [BYTE_W-1:0] MAXC_B  = BYTE_W'(MAX_CNT);
  localparam logic [IDX_W-1:0]  NREG_I  = IDX_W'(NREG);
  localparam logic [IDX_W-1:0]  MAXC_I  = IDX_W'(MAX_CNT);

  phase_e            phase_q, nxt_q, nph_c;
  logic [3:0]        bits_q;
  logic [BYTE_W-1:0] rx_q, tx_q, load_c;
  logic              hack_q, oe_q, ack_c, we_c, rx_ph, tx_ph;
  logic [IDX_W-1:0]  cnt_q, idx_q, rdx_q;

  assign rx_ph = (phase_q == PH_ADDR) || (phase_q == PH_CMD) ||
                 (phase_q == PH_CNT)  || (phase_q == PH_WDATA);
  assign tx_ph = (phase_q == PH_TXCNT) || (phase_q == PH_TXDATA);

  // decision on a completed received byte
  always_comb begin
    ack_c = 1'b0;
    we_c  = 1'b0;
    nph_c = PH_IGNORE;
    unique case (phase_q)
      PH_ADDR: if (rx_q[7:1] == DEV_ADDR) begin
        ack_c = 1'b1;
        nph_c = rx_q[0] ? PH_TXCNT : PH_CMD;
      end
      PH_CMD: if (rx_q == '0) begin
        ack_c = 1'b1;
        nph_c = PH_CNT;
      end
      PH_CNT: if (rx_q != '0 && rx_q <= MAXC_B) begin
        ack_c = 1'b1;
        nph_c = PH_WDATA;
      end
      PH_WDATA: if (idx_q < cnt_q) begin
        ack_c = 1'b1;
        nph_c = PH_WDATA;
        we_c  = (idx_q < NREG_I) && ((cnt_q <= NREG_I) || (cnt_q == MAXC_I));
      end
      default: ;
    endcase
  end

  assign load_c  = (rdx_q < NREG_I) ? rdata_i : '1;
  assign raddr_o = rdx_q[AW-1:0];
  assign waddr_o = idx_q[AW-1:0];
  assign wdata_o = rx_q;
  assign we_o    = !pwr_dn_i && scl_fall_i && bits_q == 4'd8 &&
                   phase_q == PH_WDATA && ack_c && we_c;
  assign sda_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      nxt_q   <= PH_IDLE;
      bits_q  <= '0;
      rx_q    <= '0;
      tx_q    <= '1;
      hack_q  <= 1'b1;
      oe_q    <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      rdx_q   <= '0;
    end else if (pwr_dn_i) begin
      phase_q <= PH_IDLE;
      bits_q  <= '0;
      oe_q    <= 1'b0;
    end else if (start_i) begin
      phase_q <= PH_ADDR;
      bits_q  <= '0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      phase_q <= PH_IDLE;
      bits_q  <= '0;
      oe_q    <= 1'b0;
    end else if (rx_ph || tx_ph) begin
      if (scl_rise_i) begin
        if (bits_q < 4'd8 && rx_ph)   rx_q   <= {rx_q[BYTE_W-2:0], sda_lvl_i};
        if (bits_q == 4'd8 && tx_ph)  hack_q <= sda_lvl_i;
        bits_q <= bits_q + 4'd1;
      end
      if (scl_fall_i) begin
        if (bits_q == 4'd8) begin
          if (rx_ph) begin
            oe_q  <= ack_c;
            nxt_q <= nph_c;
            if (phase_q == PH_CNT) begin
              cnt_q <= rx_q[IDX_W-1:0];
              idx_q <= '0;
            end
            if (phase_q == PH_WDATA && ack_c) idx_q <= idx_q + 1'b1;
          end else begin
            oe_q <= 1'b0;                 // host ACK slot
          end
        end else if (bits_q == 4'd9) begin
          bits_q <= '0;
          if (rx_ph) begin
            if (nxt_q == PH_TXCNT) begin
              phase_q <= PH_TXCNT;
              tx_q    <= LEN_B;
              oe_q    <= ~LEN_B[BYTE_W-1];
              rdx_q   <= '0;
            end else begin
              phase_q <= nxt_q;
              oe_q    <= 1'b0;
            end
          end else if (hack_q) begin
            phase_q <= PH_IGNORE;
            oe_q    <= 1'b0;
          end else begin
            phase_q <= PH_TXDATA;
            tx_q    <= load_c;
            oe_q    <= ~load_c[BYTE_W-1];
            if (rdx_q < NREG_I) rdx_q <= rdx_q + 1'b1;
          end
        end else if (bits_q != 4'd0 && tx_ph) begin
          tx_q <= {tx_q[BYTE_W-2:0], 1'b1};
          oe_q <= ~tx_q[BYTE_W-2];
        end
      end
    end
  end

  // R12
  pdn_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |=> !oe_q);

  // R4
  we_len_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> ((cnt_q != '0 && cnt_q <= NREG_I) || cnt_q == MAXC_I));

  // R7
  we_in_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (idx_q < cnt_q));

  // R3
  sda_pull_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !scl_lvl_i);

  // R10
  ignore_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IGNORE && $past(phase_q) == PH_IGNORE) |-> !oe_q);
endmodule

// File: rtl/smb_clk_en_regs.sv
module smb_clk_en_regs #(
  parameter logic [6:0] DEV_ADDR = 7'b1101001,
  parameter int         NREG     = 5,
  parameter int         MAX_CNT  = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pwr_dn_i,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  output logic [NREG*8-1:0]      en_regs_o
);
  localparam int AW    = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int IDX_W = $clog2(MAX_CNT + 1);
  localparam int BW    = smb_pkg::BYTE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev, we;
  logic [AW-1:0] waddr, raddr;
  logic [BW-1:0] wdata, rdata;

  smb_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  smb_engine #(
    .DEV_ADDR (DEV_ADDR),
    .NREG     (NREG),
    .MAX_CNT  (MAX_CNT),
    .AW       (AW),
    .IDX_W    (IDX_W)
  ) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_dn_i   (pwr_dn_i),
    .scl_lvl_i  (scl_s),
    .sda_lvl_i  (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_ev),
    .stop_i     (stop_ev),
    .rdata_i    (rdata),
    .raddr_o    (raddr),
    .we_o       (we),
    .waddr_o    (waddr),
    .wdata_o    (wdata),
    .sda_oe_o   (sda_oe_o)
  );

  smb_regbank #(
    .NREG (NREG),
    .AW   (AW)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata),
    .regs_o  (en_regs_o)
  );

  // R12
  pdn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_dn_i && $past(pwr_dn_i)) |-> $stable(en_regs_o));
endmodule

// File: tb/sim_smb_clk_en_regs.sv
module sim_smb_clk_en_regs;
  localparam int CLK_P = 10;
  localparam int Q = 8;
  localparam int H = 16;
  localparam logic [6:0] DEV = 7'b1101001;

  logic clk = 1'b0, rst_n = 1'b0, pdn = 1'b0, scl_h = 1'b1, sda_h = 1'b1;
  logic sda_oe;
  logic [39:0] regs;
  wire sda_line = sda_h & ~sda_oe;

  int n_run = 0, n_fail = 0;
  logic [7:0] mdl [5];
  logic [7:0] wbuf [40];
  logic [7:0] rbuf [16];
  logic [63:0] acks;

  always #(CLK_P/2) clk = ~clk;

  smb_clk_en_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_dn_i(pdn), .scl_i(scl_h),
    .sda_i(sda_line), .sda_oe_o(sda_oe), .en_regs_o(regs)
  );

  task automatic wait_c(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, longint act, longint expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic chk_regs(string req);
    for (int k = 0; k < 5; k++) chk(req, $sformatf("reg %0d", k), regs[k*8 +: 8], mdl[k]);
  endtask

  task automatic bus_start();
    sda_h = 1; scl_h = 1; wait_c(Q);
    sda_h = 0; wait_c(Q);
    scl_h = 0; wait_c(Q);
  endtask

  task automatic bus_rstart();
    sda_h = 1; wait_c(Q);
    scl_h = 1; wait_c(Q);
    sda_h = 0; wait_c(Q);
    scl_h = 0; wait_c(Q);
  endtask

  task automatic bus_stop();
    sda_h = 0; wait_c(Q);
    scl_h = 1; wait_c(Q);
    sda_h = 1; wait_c(2*Q);
  endtask

  task automatic tx_byte(input logic [7:0] b, input bit race, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wait_c(Q);
      scl_h = 1; wait_c(H);
      scl_h = 0; wait_c(Q);
    end
    sda_h = 1; wait_c(Q);
    scl_h = 1; wait_c(H/2);
    ack = (sda_line == 1'b0);
    if (race) begin
      pdn = 1; wait_c(2);
      chk("R12", "SDA released during ACK clock", sda_oe, 0);
    end
    wait_c(H/2);
    scl_h = 0; wait_c(Q);
  endtask

  task automatic rx_byte(input bit hack, output logic [7:0] b);
    sda_h = 1;
    for (int i = 7; i >= 0; i--) begin
      wait_c(Q);
      scl_h = 1; wait_c(H/2);
      b[i] = sda_line; wait_c(H/2);
      scl_h = 0;
    end
    wait_c(2);
    sda_h = hack ? 1'b0 : 1'b1; wait_c(Q);
    scl_h = 1; wait_c(H);
    scl_h = 0; wait_c(Q);
    sda_h = 1;
  endtask

  task automatic blk_write(input logic [7:0] ab, input logic [7:0] cmd, input logic [7:0] cnt,
                           input int nd, input bit race, output logic [63:0] a);
    bit k;
    a = '0;
    bus_start();
    tx_byte(ab, race, k);  a[0] = k;
    tx_byte(cmd, 0, k);    a[1] = k;
    tx_byte(cnt, 0, k);    a[2] = k;
    for (int i = 0; i < nd; i++) begin
      tx_byte(wbuf[i], 0, k); a[3+i] = k;
    end
    bus_stop();
  endtask

  task automatic blk_read(input int nb, output logic [63:0] a);
    bit k;
    logic [7:0] b;
    a = '0;
    bus_start();
    tx_byte({DEV, 1'b0}, 0, k); a[0] = k;
    tx_byte(8'h00, 0, k);       a[1] = k;
    bus_rstart();
    tx_byte({DEV, 1'b1}, 0, k); a[2] = k;
    for (int i = 0; i < nb; i++) begin
      rx_byte(i != nb - 1, b);
      rbuf[i] = b;
    end
    wait_c(4);
    chk("R10", "SDA released after host NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R11", "SDA released after reset", sda_oe, 0);
    chk("R11", "all enables set after reset", regs, 40'hFF_FFFF_FFFF);
  endtask

  task automatic t_write_short();
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h0F;
    blk_write({DEV, 1'b0}, 8'h00, 8'd3, 3, 0, acks);
    chk("R1", "own address ACK", acks[0], 1);
    chk("R2", "zero command ACK", acks[1], 1);
    chk("R3", "count and data ACKs", acks[5:2], 4'hF);
    mdl[0] = 8'hA5; mdl[1] = 8'h3C; mdl[2] = 8'h0F;
    chk_regs("R3");
  endtask

  task automatic t_read_back();
    blk_read(6, acks);
    chk("R8", "read preamble ACKs", acks[2:0], 3'b111);
    chk("R8", "length byte", rbuf[0], 5);
    for (int k = 0; k < 5; k++) chk("R8", $sformatf("read reg %0d", k), rbuf[k+1], mdl[k]);
  endtask

  task automatic t_read_past();
    blk_read(8, acks);
    chk("R9", "byte after last reg", rbuf[6], 8'hFF);
    chk("R9", "second byte after last reg", rbuf[7], 8'hFF);
    chk("R9", "last reg still correct", rbuf[5], mdl[4]);
  endtask

  task automatic t_bad_addr();
    wbuf[0] = 8'h00; wbuf[1] = 8'h00;
    blk_write({7'h52, 1'b0}, 8'h00, 8'd2, 2, 0, acks);
    chk("R1", "foreign address no ACKs", acks, 0);
    chk_regs("R1");
  endtask

  task automatic t_bad_cmd();
    wbuf[0] = 8'h00; wbuf[1] = 8'h00;
    blk_write({DEV, 1'b0}, 8'h10, 8'd2, 2, 0, acks);
    chk("R2", "nonzero command NACK", acks, 64'h1);
    chk_regs("R2");
  endtask

  task automatic t_bad_count();
    wbuf[0] = 8'h00; wbuf[1] = 8'h00;
    blk_write({DEV, 1'b0}, 8'h00, 8'd0, 1, 0, acks);
    chk("R4", "count 0 NACK", acks, 64'h3);
    blk_write({DEV, 1'b0}, 8'h00, 8'd33, 2, 0, acks);
    chk("R4", "count 33 NACK", acks, 64'h3);
    chk_regs("R4");
  endtask

  task automatic t_ign_count();
    for (int i = 0; i < 8; i++) wbuf[i] = 8'h11 * i[7:0];
    blk_write({DEV, 1'b0}, 8'h00, 8'd8, 8, 0, acks);
    chk("R5", "count 8 all ACKed", acks, 64'h7FF);
    chk_regs("R5");
  endtask

  task automatic t_max_count();
    for (int i = 0; i < 32; i++) wbuf[i] = 8'h40 + 8'(i * 3);
    blk_write({DEV, 1'b0}, 8'h00, 8'd32, 32, 0, acks);
    chk("R6", "count 32 all ACKed", acks, 64'h7_FFFF_FFFF);
    for (int k = 0; k < 5; k++) mdl[k] = wbuf[k];
    chk_regs("R6");
  endtask

  task automatic t_overrun();
    wbuf[0] = 8'hC3; wbuf[1] = 8'h81; wbuf[2] = 8'h7E;
    blk_write({DEV, 1'b0}, 8'h00, 8'd2, 3, 0, acks);
    chk("R7", "extra byte NACKed", acks, 64'h1F);
    mdl[0] = 8'hC3; mdl[1] = 8'h81;
    chk_regs("R7");
  endtask

  task automatic t_early_nack();
    blk_read(1, acks);
    chk("R10", "length byte before NACK", rbuf[0], 5);
    blk_read(2, acks);
    chk("R10", "next read after early NACK", rbuf[1], mdl[0]);
  endtask

  task automatic t_pdn();
    wbuf[0] = 8'h12; wbuf[1] = 8'h34;
    blk_write({DEV, 1'b0}, 8'h00, 8'd2, 2, 1, acks);
    chk("R12", "only address ACKed before power-down", acks, 64'h1);
    chk_regs("R12");
    blk_write({DEV, 1'b0}, 8'h00, 8'd2, 2, 0, acks);
    chk("R12", "bus ignored in power-down", acks, 0);
    chk_regs("R12");
    pdn = 0; wait_c(4);
    blk_write({DEV, 1'b0}, 8'h00, 8'd2, 2, 0, acks);
    chk("R12", "ACKs after power-down ends", acks, 64'h1F);
    mdl[0] = 8'h12; mdl[1] = 8'h34;
    chk_regs("R12");
  endtask

  initial begin
    for (int k = 0; k < 5; k++) mdl[k] = 8'hFF;
    wait_c(5);
    rst_n = 1;
    wait_c(5);
    t_reset();
    t_write_short();
    t_read_back();
    t_read_past();
    t_bad_addr();
    t_bad_cmd();
    t_bad_count();
    t_ign_count();
    t_max_count();
    t_overrun();
    t_early_nack();
    t_pdn();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule